// File: doc/BRIEF.md
# Coherent Byte Window onto a Loop-Filter Accumulator

This block holds a wide two's-complement accumulator for a timing loop filter. Each time the update strobe pulses, it adds a signed increment to the accumulator. Software on an 8-bit register bus sees only the upper sixteen bits of the accumulator, split over two byte addresses.

Reads use a two-step protocol so that software sees one coherent value. Reading the low byte returns that byte and, in the same cycle, freezes the upper byte into a holding register. The following read of the high byte returns the frozen byte. The holding register is shared with other snapshot-style registers elsewhere on the chip, and a capture by any of them overwrites it.

Writes also go low byte first. The low byte is only staged. Writing the high byte loads the staged low byte and the new high byte into the window in one cycle and clears the bits below the window. Other bus traffic may fall between the two writes.

Top module: `acc_win_reg`

## Requirements
- R1: After reset, the accumulator, the holding byte, the staged byte and the read data output are all zero.
- R2: When `upd_i` is high and no commit happens, the accumulator becomes its old value plus `upd_val_i` sign-extended, modulo 2^31, one cycle later. With neither an update nor a commit, the accumulator holds its value.
- R3: A read of address 0x5E puts accumulator bits 22:15 on `rdata_o` one cycle later, and in the same cycle copies accumulator bits 30:23 into the holding byte.
- R4: A read of address 0x5F puts the holding byte on `rdata_o` one cycle later, not the live accumulator bits.
- R5: A read of address 0x5F with no read of 0x5E before it returns whatever the holding byte last captured.
- R6: A pulse on `ext_cap_i` loads `ext_byte_i` into the holding byte. When this pulse comes in the same cycle as a read of 0x5E, the read of 0x5E takes priority.
- R7: A write to 0x5E only stages `wdata_i` and leaves the accumulator untouched.
- R8: A write to 0x5F sets accumulator bits 30:23 to `wdata_i` and bits 22:15 to the staged byte, and clears bits 14:0, one cycle later.
- R9: Reads, writes to other addresses and updates between the two writes leave the staged byte unchanged.
- R10: When a write to 0x5F and an update happen in the same cycle, the write takes effect and the update is dropped.
- R11: Reads and writes of any other address do not change `rdata_o`, the accumulator or the staged byte. `rdata_o` holds its value whenever 0x5E and 0x5F are not being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_i | input | 1 | Bus read strobe, one cycle per access |
| wr_i | input | 1 | Bus write strobe, one cycle per access |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after a read |
| upd_i | input | 1 | Accumulator update strobe |
| upd_val_i | input | IN_W | Signed increment |
| ext_cap_i | input | 1 | Snapshot capture by another register |
| ext_byte_i | input | DATA_W | Byte captured by that other register |
| acc_o | output | ACC_W | Full accumulator value |

## Verification
The bench builds the block with its default parameters: a 31-bit accumulator, 8-bit bus bytes, 16-bit signed increments, and the window registers at 0x5E and 0x5F. With these sizes, a committed window of 0x7FFF reaches the sign flip after two small updates, so the test can show wrap-around. The 8-bit address space also lets random traffic hit foreign addresses often.

// File: rtl/acc_win_pkg.sv
package acc_win_pkg;

    // One-hot-or-none decoded bus operation for the window registers
    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
    } bus_op_t;

endpackage

// File: rtl/acc_win_decode.sv
module acc_win_decode
    import acc_win_pkg::*;
#(
    parameter int unsigned             ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]       LO_ADDR = 8'h5E,
    parameter logic [ADDR_W-1:0]       HI_ADDR = 8'h5F
) (
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output bus_op_t           op_o
);

    logic hit_lo;
    logic hit_hi;

    always_comb begin
        hit_lo      = (addr_i == LO_ADDR);
        hit_hi      = (addr_i == HI_ADDR);
        op_o        = '0;
        op_o.rd_lo  = rd_i & hit_lo;
        op_o.rd_hi  = rd_i & hit_hi;
        op_o.wr_lo  = wr_i & hit_lo;
        op_o.wr_hi  = wr_i & hit_hi;
    end

endmodule

// File: rtl/acc_win_hold.sv
module acc_win_hold
    import acc_win_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  bus_op_t           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] live_lo_i,
    input  logic [DATA_W-1:0] live_hi_i,
    input  logic              ext_cap_i,
    input  logic [DATA_W-1:0] ext_byte_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] snap_o,
    output logic [DATA_W-1:0] stage_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] snap;
        logic [DATA_W-1:0] stage;
    } hold_st_t;

    hold_st_t st_d;
    hold_st_t st_q;

    always_comb begin
        st_d = st_q;
        // Holding byte: own low read takes priority over a foreign capture
        if (op_i.rd_lo) begin
            st_d.snap  = live_hi_i;
            st_d.rdata = live_lo_i;
        end else if (ext_cap_i) begin
            st_d.snap  = ext_byte_i;
        end
        if (op_i.rd_hi) begin
            st_d.rdata = st_q.snap;
        end
        if (op_i.wr_lo) begin
            st_d.stage = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign snap_o  = st_q.snap;
    assign stage_o = st_q.stage;

endmodule

// File: rtl/acc_win_accum.sv
module acc_win_accum #(
    parameter int unsigned ACC_W = 31,
    parameter int unsigned WIN_W = 16,
    parameter int unsigned IN_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             commit_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             upd_i,
    input  logic [IN_W-1:0]  upd_val_i,
    output logic [ACC_W-1:0] acc_o
);

    localparam int unsigned PAD_W = ACC_W - WIN_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t          st_d;
    acc_st_t          st_q;
    logic [ACC_W-1:0] load_val;
    logic [ACC_W-1:0] inc_val;

    generate
        if (PAD_W > 0) begin : g_pad
            assign load_val = {win_i, {PAD_W{1'b0}}};
        end else begin : g_full
            assign load_val = win_i;
        end
    endgenerate

    assign inc_val = ACC_W'(signed'(upd_val_i));

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.acc = load_val;
        end else if (upd_i) begin
            st_d.acc = st_q.acc + inc_val;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/acc_win_reg.sv
module acc_win_reg
    import acc_win_pkg::*;
#(
    parameter int unsigned       ACC_W   = 31,
    parameter int unsigned       DATA_W  = 8,
    parameter int unsigned       IN_W    = 16,
    parameter int unsigned       ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h5E,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h5F
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              upd_i,
    input  logic [IN_W-1:0]   upd_val_i,
    input  logic              ext_cap_i,
    input  logic [DATA_W-1:0] ext_byte_i,
    output logic [ACC_W-1:0]  acc_o
);

    localparam int unsigned WIN_W = 2 * DATA_W;
    localparam int unsigned LO_B  = ACC_W - WIN_W;
    localparam int unsigned HI_B  = LO_B + DATA_W;

    bus_op_t           op;
    logic [DATA_W-1:0] snap_w;
    logic [DATA_W-1:0] stage_w;
    logic [ACC_W-1:0]  acc_w;

    acc_win_decode #(
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_dec (
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .addr_i (addr_i),
        .op_o   (op)
    );

    acc_win_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .op_i       (op),
        .wdata_i    (wdata_i),
        .live_lo_i  (acc_w[LO_B +: DATA_W]),
        .live_hi_i  (acc_w[HI_B +: DATA_W]),
        .ext_cap_i  (ext_cap_i),
        .ext_byte_i (ext_byte_i),
        .rdata_o    (rdata_o),
        .snap_o     (snap_w),
        .stage_o    (stage_w)
    );

    acc_win_accum #(
        .ACC_W (ACC_W),
        .WIN_W (WIN_W),
        .IN_W  (IN_W)
    ) u_acc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .commit_i  (op.wr_hi),
        .win_i     ({wdata_i, stage_w}),
        .upd_i     (upd_i),
        .upd_val_i (upd_val_i),
        .acc_o     (acc_w)
    );

    assign acc_o = acc_w;

endmodule

// File: rtl/acc_win_reg_chk.sv
module acc_win_reg_chk #(
    parameter int unsigned       ACC_W   = 31,
    parameter int unsigned       DATA_W  = 8,
    parameter int unsigned       IN_W    = 16,
    parameter int unsigned       ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h5E,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h5F
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              upd_i,
    input logic [IN_W-1:0]   upd_val_i,
    input logic              ext_cap_i,
    input logic [DATA_W-1:0] ext_byte_i,
    input logic [ACC_W-1:0]  acc_o,
    input logic [DATA_W-1:0] snap_i,
    input logic [DATA_W-1:0] stage_i
);

    localparam int unsigned WIN_W = 2 * DATA_W;
    localparam int unsigned LO_B  = ACC_W - WIN_W;
    localparam int unsigned HI_B  = LO_B + DATA_W;

    logic             rlo;
    logic             rhi;
    logic             wlo;
    logic             whi;
    logic [ACC_W-1:0] inc_x;

    assign rlo   = rd_i && (addr_i == LO_ADDR);
    assign rhi   = rd_i && (addr_i == HI_ADDR);
    assign wlo   = wr_i && (addr_i == LO_ADDR);
    assign whi   = wr_i && (addr_i == HI_ADDR);
    assign inc_x = ACC_W'(signed'(upd_val_i));

    a_r2_update_adds: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && !whi) |=> (acc_o == $past(acc_o) + $past(inc_x)));

    a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!upd_i && !whi) |=> $stable(acc_o));

    a_r3_low_read_data: assert property (@(posedge clk_i) disable iff (rst_i)
        rlo |=> (rdata_o == $past(acc_o[LO_B +: DATA_W])));

    a_r3_low_read_freeze: assert property (@(posedge clk_i) disable iff (rst_i)
        rlo |=> (snap_i == $past(acc_o[HI_B +: DATA_W])));

    a_r4_high_read_snap: assert property (@(posedge clk_i) disable iff (rst_i)
        rhi |=> (rdata_o == $past(snap_i)));

    a_r6_ext_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        (ext_cap_i && !rlo) |=> (snap_i == $past(ext_byte_i)));

    a_r7_stage_only_low_write: assert property (@(posedge clk_i) disable iff (rst_i)
        !wlo |=> $stable(stage_i));

    a_r8_commit_window: assert property (@(posedge clk_i) disable iff (rst_i)
        whi |=> (acc_o[LO_B +: WIN_W] == {$past(wdata_i), $past(stage_i)})
                && ((acc_o << WIN_W) == '0));

    a_r10_commit_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (whi && upd_i) |=> ((acc_o << WIN_W) == '0));

    a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rlo || rhi) |=> $stable(rdata_o));

endmodule

bind acc_win_reg acc_win_reg_chk #(
    .ACC_W   (ACC_W),
    .DATA_W  (DATA_W),
    .IN_W    (IN_W),
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .upd_i      (upd_i),
    .upd_val_i  (upd_val_i),
    .ext_cap_i  (ext_cap_i),
    .ext_byte_i (ext_byte_i),
    .acc_o      (acc_o),
    .snap_i     (snap_w),
    .stage_i    (stage_w)
);

// File: tb/acc_win_reg_test.sv
module acc_win_reg_test;

    localparam logic [7:0] A_LO = 8'h5E;
    localparam logic [7:0] A_HI = 8'h5F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        upd = 1'b0;
    logic [15:0] upd_val = '0;
    logic        cap = 1'b0;
    logic [7:0]  cap_byte = '0;
    logic [30:0] acc;

    always #4 clk = ~clk;

    acc_win_reg uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .rd_i       (rd),
        .wr_i       (wr),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .upd_i      (upd),
        .upd_val_i  (upd_val),
        .ext_cap_i  (cap),
        .ext_byte_i (cap_byte),
        .acc_o      (acc)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Reference state, built from the requirements
    logic [30:0] m_acc   = '0;
    logic [7:0]  m_snap  = '0;
    logic [7:0]  m_stage = '0;
    logic [7:0]  m_rdata = '0;

    function automatic logic [30:0] f_acc(input logic [30:0] a, input logic commit,
                                          input logic [15:0] win, input logic u,
                                          input logic [15:0] v);
        if (commit) return {win, 15'b0};
        if (u)      return a + {{15{v[15]}}, v};
        return a;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge, check after the next rising edge
    task automatic step(input logic r, input logic w, input logic [7:0] a,
                        input logic [7:0] wd, input logic u, input logic [15:0] v,
                        input logic c, input logic [7:0] cb, input string note);
        logic        rlo, rhi, wlo, whi;
        logic [30:0] e_acc;
        logic [7:0]  e_rd, e_snap, e_stage;
        string       t_acc, t_rd;
        rd = r; wr = w; addr = a; wdata = wd; upd = u; upd_val = v;
        cap = c; cap_byte = cb;
        rlo = r && (a == A_LO); rhi = r && (a == A_HI);
        wlo = w && (a == A_LO); whi = w && (a == A_HI);
        e_acc   = f_acc(m_acc, whi, {wd, m_stage}, u, v);
        e_rd    = rlo ? m_acc[22:15] : (rhi ? m_snap : m_rdata);
        e_snap  = rlo ? m_acc[30:23] : (c ? cb : m_snap);
        e_stage = wlo ? wd : m_stage;
        t_acc = (whi && u) ? "R10" : (whi ? "R8" : (wlo ? "R7" : "R2"));
        t_rd  = rlo ? "R3" : (rhi ? "R4" : "R11");
        @(posedge clk);
        @(negedge clk);
        check({t_acc, " ", note}, "acc", {1'b0, acc}, {1'b0, e_acc});
        check({t_rd, " ", note}, "rdata", {24'b0, rdata}, {24'b0, e_rd});
        m_acc = e_acc; m_rdata = e_rd; m_snap = e_snap; m_stage = e_stage;
        rd = 0; wr = 0; upd = 0; cap = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 8'h00, 0, 16'h0, 0, 8'h00, "idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r1, r2;
        logic [7:0]  ra;
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "acc", {1'b0, acc}, 32'h0);
        check("R1", "rdata", {24'b0, rdata}, 32'h0);
        step(1, 0, A_HI, 8'h00, 0, 16'h0, 0, 8'h00, "R1 zero holding byte");

        // R2: plain updates, positive and negative
        step(0, 0, 8'h00, 8'h00, 1, 16'h1234, 0, 8'h00, "R2");
        step(0, 0, 8'h00, 8'h00, 1, 16'hFFF0, 0, 8'h00, "R2 negative");

        // R7/R8: stage then commit 0x7FFF, then R2 wrap into the sign bit
        step(0, 1, A_LO, 8'hFF, 0, 16'h0, 0, 8'h00, "R7");
        step(0, 1, A_HI, 8'h7F, 0, 16'h0, 0, 8'h00, "R8");
        check("R8", "acc literal", {1'b0, acc}, 32'h3FFF8000);
        step(0, 0, 8'h00, 8'h00, 1, 16'h7FFF, 0, 8'h00, "R2");
        step(0, 0, 8'h00, 8'h00, 1, 16'h0001, 0, 8'h00, "R2 wrap");
        check("R2", "wrap literal", {1'b0, acc}, 32'h40000000);

        // R3/R4: low read freezes high byte, later updates do not leak in
        step(1, 0, A_LO, 8'h00, 0, 16'h0, 0, 8'h00, "R3");
        step(0, 0, 8'h00, 8'h00, 1, 16'h8000, 0, 8'h00, "R4 update between");
        step(0, 0, 8'h00, 8'h00, 1, 16'h8000, 0, 8'h00, "R4 update between");
        step(1, 0, A_HI, 8'h00, 0, 16'h0, 0, 8'h00, "R4");
        check("R4", "frozen literal", {24'b0, rdata}, 32'h80);
        // R5: high read again without a fresh low read
        step(1, 0, A_HI, 8'h00, 0, 16'h0, 0, 8'h00, "R5");

        // R6: foreign capture replaces the holding byte; low read wins a tie
        step(0, 0, 8'h00, 8'h00, 0, 16'h0, 1, 8'hA5, "R6");
        step(1, 0, A_HI, 8'h00, 0, 16'h0, 0, 8'h00, "R6");
        check("R6", "foreign literal", {24'b0, rdata}, 32'hA5);
        step(1, 0, A_LO, 8'h00, 0, 16'h0, 1, 8'h3C, "R6 tie");
        step(1, 0, A_HI, 8'h00, 0, 16'h0, 0, 8'h00, "R6 tie");

        // R9: traffic between the two writes keeps the staged byte
        step(0, 1, A_LO, 8'h5A, 0, 16'h0, 0, 8'h00, "R9");
        step(1, 0, A_LO, 8'h00, 1, 16'h0101, 0, 8'h00, "R9");
        step(0, 1, 8'h20, 8'hEE, 0, 16'h0, 0, 8'h00, "R9 R11");
        step(1, 0, 8'h21, 8'h00, 0, 16'h0, 1, 8'h11, "R9 R11");
        step(0, 1, A_HI, 8'hC3, 0, 16'h0, 0, 8'h00, "R9");
        check("R9", "commit literal", {1'b0, acc}, {1'b0, 8'hC3, 8'h5A, 15'b0});

        // R10: commit and update in the same cycle
        step(0, 1, A_LO, 8'h01, 0, 16'h0, 0, 8'h00, "R10");
        step(0, 1, A_HI, 8'h02, 1, 16'h7777, 0, 8'h00, "R10");
        check("R10", "commit literal", {1'b0, acc}, {1'b0, 16'h0201, 15'b0});

        // R11: foreign addresses
        step(1, 0, 8'h5D, 8'h00, 0, 16'h0, 0, 8'h00, "R11");
        step(0, 1, 8'h60, 8'h99, 0, 16'h0, 0, 8'h00, "R11");
        idle(2);

        // Random traffic mixed over all operations
        for (int n = 0; n < 4000; n++) begin
            r1 = $urandom;
            r2 = $urandom;
            case (r1[2:0])
                3'd0, 3'd1: ra = A_LO;
                3'd2, 3'd3: ra = A_HI;
                default:    ra = r2[15:8];
            endcase
            step(r1[3] & ~r1[4], r1[4], ra, r2[7:0], r1[5], r1[31:16],
                 (r1[8:6] == 3'd0), r2[23:16], "random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule